// File: doc/BRIEF.md
# Wiper Register Bank With Non-Volatile Control

This block holds the digital state behind four potentiometer wipers. Each wiper has a 7-bit working register that drives the wiper code outputs, and a non-volatile initial-value cell that the working register is reloaded from after power comes up. Three general-purpose non-volatile bytes and one control register sit beside them. A serial front end outside the block decodes frames and presents one byte access at a time on a simple register bus. It also pulses `frame_end` when the chip select is released.

The control register chooses which copy an access to addresses 0..3 reaches: the volatile working register or the non-volatile cell. A write to a non-volatile location is held until the frame closes. At that point it is committed, and a busy period begins. The busy period is a cycle counter that stands in for the self-timed cell programming. While it runs, every write is refused. The shutdown flag combines a control bit with an active-low pin. Non-volatile cells are flip-flops that take their factory value on `rst_n`. A low `pwr_good` models the supply ramp.

Top module: `wiper_nv_bank`

## Requirements
- R1: After reset, with `pwr_good` and `shdn_n` high, the control register (address 8) reads 40h, every wiper code is 40h, and `shutdown` is 0.
- R2: Control bit 7 selects the copy seen at addresses 0..3: 0 reaches the non-volatile cell, 1 reaches only the working register. Reads return the 7-bit value with bit 7 zero.
- R3: A write to a non-volatile wiper cell loads the working register on the next clock. The cell itself changes only when `frame_end` is pulsed, so it reads its old value until then. Reading a cell never changes a working register.
- R4: Only the first byte aimed at a non-volatile location within a frame is accepted. Later such bytes in that frame change neither a cell nor a working register.
- R5: A commit sets control bit 5 (busy) for `BUSY_CYCLES` clocks. While it is set, writes to every address are refused.
- R6: `shutdown` is 1 when control bit 6 is 0 or `shdn_n` is low. Wiper codes and register access are unaffected by shutdown.
- R7: While `pwr_good` is low, all wiper codes are forced to 40h, the control register returns to its defaults, and writes are ignored. On the first clock with `pwr_good` high, each working register is loaded from its non-volatile cell.
- R8: Addresses 4..6 are 8-bit non-volatile bytes. They are reachable whatever bit 7 holds, and they commit at frame end with a busy period like the wiper cells.
- R9: Reads of address 7 and of addresses 9..15 return 0. Writes to them change nothing and start no busy period.
- R10: Control bits 4:0 always read 0, and bit 5 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply valid; low forces the power-up state |
| shdn_n | input | 1 | Shutdown pin, active low |
| bus_addr | input | 4 | Register address of the current access |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| frame_end | input | 1 | One-cycle pulse when the serial frame closes |
| wiper_code | output | 28 | Four 7-bit wiper codes, wiper 0 in bits 6:0 |
| shutdown | output | 1 | Wipers are to be parked |

## Verification
A table of accesses walks through both states of the copy-select bit on the same addresses. This shows whether reads are steered to the cell or to the working register, and whether a cell write also reaches the wiper. Two non-volatile bytes are sent in one frame, and the cell is read before and after `frame_end`. This separates a first-byte-only commit from a last-byte-wins commit, and a deferred commit from an immediate one. Directed runs then issue writes to the control register, a general byte and a wiper during busy. They drop `pwr_good` after the wipers were set to values that differ from the cells, so a recall can be told apart from a simple hold. They drive both sources of shutdown separately, and they write to the reserved holes.

// File: rtl/wnb_pkg.sv
// Package: shared sizing and the fixed power-up wiper code for the wiper bank.
package wnb_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = 7;
    localparam logic [CODE_W-1:0] MID_CODE = 7'h40;

    // Control register image from its three live bits.
    function automatic logic [DATA_W-1:0] ctrl_image(input logic vol, input logic run, input logic busy);
        return {vol, run, busy, 5'b0_0000};
    endfunction
endpackage

// File: rtl/wnb_ctrl.sv
// Module: wnb_ctrl
// Holds the copy-select and run bits and the busy counter that emulates the
// self-timed non-volatile write. Assumes wr_ctrl is already qualified by the
// caller (not busy, power good).
module wnb_ctrl #(
    parameter int BUSY_CYCLES = 2_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       start_busy,
    output logic       vol,
    output logic       run,
    output logic       busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] BUSY_LD = CW'(BUSY_CYCLES);

    logic [CW-1:0] cnt_q;

    // Control bits: defaults on reset or supply loss, else host writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            vol <= 1'b0;
            run <= 1'b1;
        end else if (wr_ctrl) begin
            vol <= wdata[7];
            run <= wdata[6];
        end
    end

    // Busy counter: loaded on commit, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_busy)
            cnt_q <= BUSY_LD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_busy_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_busy |=> busy);
endmodule

// File: rtl/wnb_nv_store.sv
// Module: wnb_nv_store
// Flip-flop model of the non-volatile cells (wiper initial values, then the
// general bytes). Stages the first accepted byte of a frame and commits it on
// frame_end. Assumes nv_wr never coincides with frame_end.
module wnb_nv_store #(
    parameter int NUM_NV = 7,
    parameter int NUM_WPR = 4,
    parameter logic [7:0] IV_INIT = 8'h40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         nv_wr,
    input  logic [$clog2(NUM_NV)-1:0]    idx,
    input  logic [7:0]                   wdata,
    input  logic                         frame_end,
    output logic                         nv_accept,
    output logic                         commit,
    output logic [NUM_NV-1:0][7:0]       nv_q
);
    localparam int IW = $clog2(NUM_NV);

    logic          pend_vld;
    logic [IW-1:0] pend_idx;
    logic [7:0]    pend_data;

    assign nv_accept = nv_wr && !pend_vld;
    assign commit    = frame_end && pend_vld;

    // Staging: keep the first non-volatile byte of the frame, drop at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            pend_vld  <= 1'b0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (nv_accept) begin
            pend_vld  <= 1'b1;
            pend_idx  <= idx;
            pend_data <= wdata;
        end
    end

    for (genvar k = 0; k < NUM_NV; k++) begin : g_cell
        localparam logic [7:0] INIT = (k < NUM_WPR) ? IV_INIT : 8'h00;
        // Cell k: factory value on reset, staged byte on its commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                nv_q[k] <= INIT;
            else if (commit && pend_idx == IW'(k))
                nv_q[k] <= pend_data;
        end

        assert_commit_at_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(nv_q[k]) |-> $past(frame_end));
    end

    assert_stage_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !pend_vld);
endmodule

// File: rtl/wnb_wipers.sv
// Module: wnb_wipers
// The working wiper registers. Forced to mid-scale while supply is not good,
// reloaded from the cells on the first good cycle, else loaded by the bus.
module wnb_wipers #(
    parameter int NUM_WPR = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   pwr_good,
    input  logic [NUM_WPR-1:0][wnb_pkg::CODE_W-1:0] iv,
    input  logic [NUM_WPR-1:0]                     load_en,
    input  logic [wnb_pkg::CODE_W-1:0]             load_data,
    output logic [NUM_WPR-1:0][wnb_pkg::CODE_W-1:0] wpr_q
);
    import wnb_pkg::*;

    logic pg_q;
    logic recall;

    // Supply history: marks the first cycle after pwr_good rises.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pwr_good;
    end

    assign recall = pwr_good && !pg_q;

    for (genvar w = 0; w < NUM_WPR; w++) begin : g_wpr
        // Wiper w: mid-scale, recall, or bus load, in that priority.
        always_ff @(posedge clk) begin
            if (!rst_n || !pwr_good)
                wpr_q[w] <= MID_CODE;
            else if (recall)
                wpr_q[w] <= iv[w];
            else if (load_en[w])
                wpr_q[w] <= load_data;
        end

        assert_powerup_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_good |=> (wpr_q[w] == MID_CODE));
    end
endmodule

// File: rtl/wiper_nv_bank.sv
// Module: wiper_nv_bank (top)
// Decodes register-bus accesses into the wiper, cell and control storage,
// steers addresses 0..NUM_WPR-1 by the copy-select bit, and forms the
// shutdown flag. Assumes one access per cycle, never in the frame_end cycle.
module wiper_nv_bank #(
    parameter int NUM_WPR     = 4,
    parameter int NUM_GP      = 3,
    parameter int CTRL_ADDR   = 8,
    parameter int BUSY_CYCLES = 2_500_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pwr_good,
    input  logic                          shdn_n,
    input  logic [3:0]                    bus_addr,
    input  logic                          bus_wr,
    input  logic [7:0]                    bus_wdata,
    output logic [7:0]                    bus_rdata,
    input  logic                          frame_end,
    output logic [NUM_WPR*7-1:0]          wiper_code,
    output logic                          shutdown
);
    import wnb_pkg::*;

    localparam int NUM_NV = NUM_WPR + NUM_GP;
    localparam int IW     = $clog2(NUM_NV);
    localparam int WW     = $clog2(NUM_WPR);
    localparam logic [ADDR_W-1:0] WPR_END  = ADDR_W'(NUM_WPR);
    localparam logic [ADDR_W-1:0] NV_END   = ADDR_W'(NUM_NV);
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);

    logic                              vol, run, busy;
    logic                              wr_ok, is_wpr, is_nv, is_ctrl;
    logic                              nv_wr, nv_accept, commit;
    logic [7:0]                        nv_wdata;
    logic [NUM_NV-1:0][7:0]            nv_q;
    logic [NUM_WPR-1:0][CODE_W-1:0]    iv, wpr_q;
    logic [NUM_WPR-1:0]                load_en;
    logic [IW-1:0]                     idx;

    // Address decode and write qualification.
    always_comb begin
        is_wpr   = bus_addr < WPR_END;
        is_nv    = bus_addr < NV_END;
        is_ctrl  = bus_addr == CTRL_A;
        wr_ok    = bus_wr && pwr_good && !busy;
        idx      = bus_addr[IW-1:0];
        nv_wr    = wr_ok && is_nv && !(is_wpr && vol);
        nv_wdata = is_wpr ? {1'b0, bus_wdata[CODE_W-1:0]} : bus_wdata;
    end

    // Working-register load enables: direct when volatile, else on cell accept.
    always_comb begin
        for (int w = 0; w < NUM_WPR; w++) begin
            load_en[w] = is_wpr && bus_addr[WW-1:0] == WW'(w)
                         && ((wr_ok && vol) || nv_accept);
        end
    end

    for (genvar w = 0; w < NUM_WPR; w++) begin : g_iv
        assign iv[w] = nv_q[w][CODE_W-1:0];
    end

    wnb_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .wr_ctrl(wr_ok && is_ctrl), .wdata(bus_wdata),
        .start_busy(commit), .vol(vol), .run(run), .busy(busy)
    );

    wnb_nv_store #(.NUM_NV(NUM_NV), .NUM_WPR(NUM_WPR), .IV_INIT({1'b0, MID_CODE})) u_store (
        .clk(clk), .rst_n(rst_n), .nv_wr(nv_wr), .idx(idx), .wdata(nv_wdata),
        .frame_end(frame_end), .nv_accept(nv_accept), .commit(commit), .nv_q(nv_q)
    );

    wnb_wipers #(.NUM_WPR(NUM_WPR)) u_wipers (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .iv(iv),
        .load_en(load_en), .load_data(bus_wdata[CODE_W-1:0]), .wpr_q(wpr_q)
    );

    // Read mux: steered wiper copy, general bytes, control image, else zero.
    always_comb begin
        bus_rdata = '0;
        if (is_wpr)
            bus_rdata = vol ? {1'b0, wpr_q[bus_addr[WW-1:0]]} : {1'b0, iv[bus_addr[WW-1:0]]};
        else if (is_nv)
            bus_rdata = nv_q[idx];
        else if (is_ctrl)
            bus_rdata = ctrl_image(vol, run, busy);
    end

    assign wiper_code = wpr_q;
    assign shutdown   = !(run && shdn_n);

    assert_ctrl_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pwr_good) |=> ($stable(vol) && $stable(run)));

    assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_nv && !is_ctrl) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_wiper_nv_bank.sv
`timescale 1ns/1ps
// Bench: table-driven access walk, then directed busy, power, shutdown and hole tests.
module test_wiper_nv_bank;
    localparam int BUSY = 16;
    localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_F = 3'd2, OP_T = 3'd3, OP_X = 3'd4;
    localparam int NVEC = 27;
    localparam logic [14:0] VEC [NVEC] = '{
        {OP_R, 4'd8, 8'h40}, {OP_R, 4'd0, 8'h40}, {OP_W, 4'd8, 8'hC0},
        {OP_W, 4'd2, 8'h15}, {OP_R, 4'd2, 8'h15}, {OP_W, 4'd8, 8'h40},
        {OP_R, 4'd2, 8'h40}, {OP_W, 4'd1, 8'h2A}, {OP_W, 4'd3, 8'h11},
        {OP_R, 4'd1, 8'h40}, {OP_F, 4'd0, 8'h00}, {OP_R, 4'd1, 8'h2A},
        {OP_R, 4'd3, 8'h40}, {OP_R, 4'd8, 8'h60}, {OP_T, 4'd0, 8'h00},
        {OP_R, 4'd8, 8'h40}, {OP_W, 4'd5, 8'hA5}, {OP_F, 4'd0, 8'h00},
        {OP_R, 4'd5, 8'hA5}, {OP_T, 4'd0, 8'h00}, {OP_X, 4'd1, 8'h2A},
        {OP_X, 4'd2, 8'h15}, {OP_X, 4'd3, 8'h40}, {OP_X, 4'd0, 8'h40},
        {OP_W, 4'd8, 8'hC0}, {OP_R, 4'd5, 8'hA5}, {OP_W, 4'd8, 8'h40}
    };

    logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1, shdn_n = 1'b1;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0, frame_end = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [27:0] wiper_code;
    logic shutdown;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wiper_nv_bank #(.BUSY_CYCLES(BUSY)) i_wiper_nv_bank (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .shdn_n(shdn_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .frame_end(frame_end),
        .wiper_code(wiper_code), .shutdown(shutdown)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wpr(input string req, input int w, input logic [6:0] exp);
        @(negedge clk); #1;
        check(req, {1'b0, wiper_code[w*7 +: 7]}, {1'b0, exp});
    endtask

    task automatic idle();
        repeat (BUSY + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 shutdown", {7'b0, shutdown}, 8'h00);
        for (int w = 0; w < 4; w++) wpr("R1 wiper", w, 7'h40);

        // Table walk: R2 steering, R3 deferred commit, R4 first byte, R5 busy, R8 general bytes
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][14:12])
                OP_W: wr(VEC[i][11:8], VEC[i][7:0]);
                OP_R: rd("R2/R3/R4/R5/R8 table read", VEC[i][11:8], VEC[i][7:0]);
                OP_F: frame();
                OP_T: idle();
                default: wpr("R3/R4 table wiper", int'(VEC[i][11:8]), VEC[i][6:0]);
            endcase
        end

        // R5: every write refused during busy
        wr(4'd0, 8'h33);
        frame();
        wr(4'd8, 8'hC0);
        wr(4'd6, 8'h77);
        wr(4'd0, 8'h55);
        rd("R5 ctrl during busy", 4'd8, 8'h60);
        wpr("R5 wiper0 held", 0, 7'h33);
        idle();
        rd("R5 gp6 unchanged", 4'd6, 8'h00);
        rd("R5 cell0 committed", 4'd0, 8'h33);
        rd("R5 ctrl idle", 4'd8, 8'h40);

        // R7: power loss forces mid-scale and defaults, then recall
        wr(4'd8, 8'hC0);
        wr(4'd0, 8'h05);
        wpr("R7 wiper0 set", 0, 7'h05);
        @(negedge clk); pwr_good = 1'b0;
        @(negedge clk);
        wpr("R7 wiper0 mid", 0, 7'h40);
        wpr("R7 wiper1 mid", 1, 7'h40);
        rd("R7 ctrl default", 4'd8, 8'h40);
        wr(4'd8, 8'hC0);
        rd("R7 write ignored", 4'd8, 8'h40);
        @(negedge clk); pwr_good = 1'b1;
        wpr("R7 recall wiper0", 0, 7'h33);
        wpr("R7 recall wiper1", 1, 7'h2A);
        wpr("R7 recall wiper2", 2, 7'h40);

        // R10: low bits and busy bit not writable
        wr(4'd8, 8'h7F);
        rd("R10 ctrl low bits", 4'd8, 8'h40);

        // R6: shutdown from the bit and from the pin, wipers kept
        wr(4'd8, 8'h3F);
        rd("R6 ctrl run=0", 4'd8, 8'h00);
        check("R6 bit shutdown", {7'b0, shutdown}, 8'h01);
        wpr("R6 wiper0 kept", 0, 7'h33);
        wr(4'd8, 8'h40);
        check("R6 normal", {7'b0, shutdown}, 8'h00);
        @(negedge clk); shdn_n = 1'b0; #1;
        check("R6 pin shutdown", {7'b0, shutdown}, 8'h01);
        rd("R6 access in shutdown", 4'd0, 8'h33);
        wr(4'd8, 8'hC0);
        rd("R6 write in shutdown", 4'd8, 8'hC0);
        wr(4'd8, 8'h40);
        @(negedge clk); shdn_n = 1'b1; #1;
        check("R6 pin released", {7'b0, shutdown}, 8'h00);
        wpr("R6 wiper1 kept", 1, 7'h2A);

        // R9: holes read zero, writes do nothing
        wr(4'd7, 8'hFF);
        wr(4'd9, 8'hFF);
        wr(4'd15, 8'hFF);
        rd("R9 addr7", 4'd7, 8'h00);
        rd("R9 addr9", 4'd9, 8'h00);
        rd("R9 addr15", 4'd15, 8'h00);
        frame();
        rd("R9 no busy", 4'd8, 8'h40);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule